// File: doc/BRIEF.md
# Peripheral Access Filter Checker

This block decides, one request at a time, whether a requester may reach one of a fixed set of peripherals. Software programs it through a small word-addressed register port. That port holds three kinds of state:

- one configuration word for each peripheral, which sets the compartment rules;
- packed words of secure-only bits, one bit per peripheral;
- a read-only word that reports how many peripheral entries exist.

A request carries a peripheral index, the requester's compartment number and a secure flag. One cycle after the strobe the block answers with grant or deny. With a grant it also raises a flag when the peripheral is in semaphore mode, so the requester must also own that peripheral's semaphore. The semaphore itself is kept elsewhere.

The compartment check is tried first and the secure check second. The compartment check has three cases:

- Filtering off, or an owner of zero, lets every compartment through.
- Filtering on with a non-zero owner admits only that owner.
- Filtering on with semaphore mode on ignores the owner. The requester's bit in an eight-entry allow list then decides.

A set secure-only bit turns away non-secure requesters.

Top module: `periph_access_filter`

## Requirements
- R1: After reset every register reads 0, rsp_valid, rsp_grant, rsp_need_sem and reg_rdata are 0, and any in-range request from any compartment, secure or not, is granted with rsp_need_sem = 0.
- R2: Every cycle with req_valid high gives exactly one cycle of rsp_valid on the next cycle, in request order. When rsp_valid is low, rsp_grant and rsp_need_sem are 0.
- R3: The entry total is CNT_A + CNT_B + CNT_C. Address 0xFEC reads {CNT_C[7:0], CNT_B[7:0], CNT_A[15:0]} and ignores writes. A request whose index is at or above the total is denied.
- R4: Peripheral i has a configuration word at byte address 0x100 + 8*i. In that word, bit 0 enables filtering, bit 1 enables semaphore mode, bits 6:4 hold the owner compartment and bits 23:16 form the allow list, with bit 16+c for compartment c. All other bits read back as 0.
- R5: With filtering off, or with an owner of 0, the compartment check passes for every compartment.
- R6: With filtering on, semaphore mode off and a non-zero owner, only a requester whose compartment equals the owner passes.
- R7: With filtering and semaphore mode both on, the owner is ignored and allow-list bit 16+cid alone decides the compartment check. A granted request then has rsp_need_sem = 1.
- R8: Secure-only bits sit at byte address 0x10 + 4*(i/32), bit i%32. A set bit denies a non-secure requester and leaves a secure one unaffected. Bits for indices at or above the total read as 0.
- R9: rsp_need_sem is 1 only on a granted response for a peripheral with both filtering and semaphore mode on. Semaphore mode without filtering has no effect.
- R10: reg_rdata takes the addressed word on the cycle after reg_re and holds it otherwise. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, updated one cycle after reg_re |
| req_valid | input | 1 | Access request strobe |
| req_idx | input | IDX_W | Peripheral index |
| req_cid | input | 3 | Requester compartment number |
| req_secure | input | 1 | Requester is secure |
| rsp_valid | output | 1 | Response valid |
| rsp_grant | output | 1 | Access granted |
| rsp_need_sem | output | 1 | Grant also needs semaphore ownership |

## Verification
The properties assume that reg_we and reg_re are never high together. They also assume that reg_addr and the request inputs are stable and known on every clock edge after reset. The bench drives all inputs on the falling edge, never issues a read and a write in the same cycle, and keeps every index within the IDX_W range. This still lets it reach indices above the entry total. Expected responses come from a shadow copy of the configuration the bench wrote, masked to the defined fields.

// File: rtl/afc_pkg.sv
package afc_pkg;
    localparam int CID_W    = 3;
    localparam int WL_W     = 1 << CID_W;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int SEC_BASE = 'h10;
    localparam int CFG_BASE = 'h100;
    localparam int CFG_STEP = 8;
    localparam int HW_ADDR  = 'hFEC;

    typedef struct packed {
        logic [WL_W-1:0]  allow;
        logic [CID_W-1:0] owner;
        logic             sem_on;
        logic             filt_on;
    } cid_cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(input cid_cfg_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[0]     = c.filt_on;
        w[1]     = c.sem_on;
        w[6:4]   = c.owner;
        w[23:16] = c.allow;
        return w;
    endfunction

    function automatic cid_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        cid_cfg_t c;
        c.filt_on = w[0];
        c.sem_on  = w[1];
        c.owner   = w[6:4];
        c.allow   = w[23:16];
        return c;
    endfunction
endpackage

// File: rtl/afc_regs.sv
module afc_regs
    import afc_pkg::*;
#(
    parameter int N      = 56,
    parameter int NSW    = (N + 31) / 32,
    parameter logic [WORD_W-1:0] HW_WORD = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wdata,
    output logic [NSW-1:0][WORD_W-1:0]  sec_o,
    output cid_cfg_t [N-1:0]            cfg_o,
    output logic [WORD_W-1:0]           rd_word
);
    typedef struct packed {
        logic [NSW-1:0][WORD_W-1:0] sec;
        cid_cfg_t [N-1:0]           cfg;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NSW-1:0][WORD_W-1:0] sec_mask;

    // bits belonging to indices beyond N never store a one
    for (genvar gw = 0; gw < NSW; gw++) begin : g_word
        for (genvar gb = 0; gb < WORD_W; gb++) begin : g_bit
            assign sec_mask[gw][gb] = ((gw * WORD_W + gb) < N) ? 1'b1 : 1'b0;
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            for (int w = 0; w < NSW; w++) begin
                if (int'(addr) == SEC_BASE + 4 * w) begin
                    regs_d.sec[w] = wdata & sec_mask[w];
                end
            end
            for (int i = 0; i < N; i++) begin
                if (int'(addr) == CFG_BASE + CFG_STEP * i) begin
                    regs_d.cfg[i] = word_to_cfg(wdata);
                end
            end
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(addr) == HW_ADDR) begin
            rd_word = HW_WORD;
        end
        for (int w = 0; w < NSW; w++) begin
            if (int'(addr) == SEC_BASE + 4 * w) begin
                rd_word = regs_q.sec[w];
            end
        end
        for (int i = 0; i < N; i++) begin
            if (int'(addr) == CFG_BASE + CFG_STEP * i) begin
                rd_word = cfg_to_word(regs_q.cfg[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sec_o = regs_q.sec;
    assign cfg_o = regs_q.cfg;
endmodule

// File: rtl/afc_decide.sv
module afc_decide
    import afc_pkg::*;
#(
    parameter int N     = 56,
    parameter int NSW   = (N + 31) / 32,
    parameter int IDX_W = 8
) (
    input  logic [NSW-1:0][WORD_W-1:0] sec_i,
    input  cid_cfg_t [N-1:0]           cfg_i,
    input  logic [IDX_W-1:0]           idx,
    input  logic [CID_W-1:0]           cid,
    input  logic                       secure,
    output logic                       grant,
    output logic                       need_sem
);
    cid_cfg_t sel_cfg;
    logic     sel_sec;
    logic     in_range;
    logic     cid_ok;
    logic     sec_ok;

    always_comb begin
        in_range = int'(idx) < N;
        sel_cfg  = '0;
        sel_sec  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(idx) == i) begin
                sel_cfg = cfg_i[i];
            end
        end
        for (int w = 0; w < NSW; w++) begin
            if (int'(idx >> 5) == w) begin
                sel_sec = sec_i[w][idx[4:0]];
            end
        end

        if (sel_cfg.filt_on && sel_cfg.sem_on) begin
            cid_ok = sel_cfg.allow[cid];
        end else if (!sel_cfg.filt_on || sel_cfg.owner == '0) begin
            cid_ok = 1'b1;
        end else begin
            cid_ok = (sel_cfg.owner == cid);
        end

        sec_ok   = !sel_sec || secure;
        grant    = in_range && cid_ok && sec_ok;
        need_sem = grant && sel_cfg.filt_on && sel_cfg.sem_on;
    end
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
    import afc_pkg::*;
#(
    parameter int CNT_A = 40,
    parameter int CNT_B = 12,
    parameter int CNT_C = 4,
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [2:0]        req_cid,
    input  logic              req_secure,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_need_sem
);
    localparam int N   = CNT_A + CNT_B + CNT_C;
    localparam int NSW = (N + 31) / 32;
    localparam logic [WORD_W-1:0] HW_WORD = {8'(CNT_C), 8'(CNT_B), 16'(CNT_A)};

    typedef struct packed {
        logic              rsp_valid;
        logic              grant;
        logic              need_sem;
        logic [WORD_W-1:0] rdata;
    } out_t;

    out_t out_d, out_q;

    logic [NSW-1:0][WORD_W-1:0] sec_w;
    cid_cfg_t [N-1:0]           cfg_w;
    logic [WORD_W-1:0]          rd_word;
    logic                       dec_grant;
    logic                       dec_sem;

    afc_regs #(.N(N), .NSW(NSW), .HW_WORD(HW_WORD)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .sec_o   (sec_w),
        .cfg_o   (cfg_w),
        .rd_word (rd_word)
    );

    afc_decide #(.N(N), .NSW(NSW), .IDX_W(IDX_W)) u_decide (
        .sec_i    (sec_w),
        .cfg_i    (cfg_w),
        .idx      (req_idx),
        .cid      (req_cid),
        .secure   (req_secure),
        .grant    (dec_grant),
        .need_sem (dec_sem)
    );

    always_comb begin
        out_d.rsp_valid = req_valid;
        out_d.grant     = req_valid && dec_grant;
        out_d.need_sem  = req_valid && dec_sem;
        out_d.rdata     = reg_re ? rd_word : out_q.rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rsp_valid    = out_q.rsp_valid;
    assign rsp_grant    = out_q.grant;
    assign rsp_need_sem = out_q.need_sem;
    assign reg_rdata    = out_q.rdata;
endmodule

// File: rtl/afc_chk.sv
module afc_chk #(
    parameter int TOTAL = 56,
    parameter int IDX_W = 8,
    parameter logic [31:0] HW_WORD = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_re,
    input logic [11:0]      reg_addr,
    input logic [31:0]      reg_rdata,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic             rsp_need_sem
);
    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_need_sem));

    // R9
    sem_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_need_sem |-> (rsp_grant && rsp_valid));

    // R3
    oob_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_idx) >= TOTAL) |=> (!rsp_grant && !rsp_need_sem));

    // R3
    hw_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && reg_addr == 12'hFEC) |=> (reg_rdata == HW_WORD));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));
endmodule

bind periph_access_filter afc_chk #(
    .TOTAL   (N),
    .IDX_W   (IDX_W),
    .HW_WORD (HW_WORD)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_re       (reg_re),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .req_valid    (req_valid),
    .req_idx      (req_idx),
    .rsp_valid    (rsp_valid),
    .rsp_grant    (rsp_grant),
    .rsp_need_sem (rsp_need_sem)
);

// File: tb/sim_periph_access_filter.sv
`timescale 1ns/1ps
module sim_periph_access_filter;
    localparam int CA = 40, CB = 12, CC = 4, IW = 8;
    localparam int NT = CA + CB + CC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_re = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [IW-1:0] req_idx = '0;
    logic [2:0]  req_cid = '0;
    logic        req_secure = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_need_sem;

    int total = 0, bad = 0, sent = 0, got = 0;
    bit done = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [31:0] cfg_sh [NT];
    logic [31:0] sec_sh [2];

    always #2.5 clk = ~clk;

    periph_access_filter #(.CNT_A(CA), .CNT_B(CB), .CNT_C(CC), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_idx(req_idx), .req_cid(req_cid),
        .req_secure(req_secure), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_need_sem(rsp_need_sem));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] model(input int idx, input int cid, input bit sec);
        logic [31:0] c;
        bit ok;
        int own;
        if (idx >= NT) return 2'b00;
        c   = cfg_sh[idx];
        own = int'(c[6:4]);
        if (c[0] && c[1])          ok = c[16 + cid];
        else if (!c[0] || own == 0) ok = 1'b1;
        else                        ok = (own == cid);
        if (sec_sh[idx / 32][idx % 32] && !sec) ok = 1'b0;
        return {ok, ok & c[0] & c[1]};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                got++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "response without request", 32'(got), 32'(sent));
                end else begin
                    logic [1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check({rsp_grant, rsp_need_sem} == e, t, "grant/need_sem",
                          32'({rsp_grant, rsp_need_sem}), 32'(e));
                end
            end else if (rsp_grant || rsp_need_sem) begin
                check(1'b0, "R2", "outputs active without rsp_valid",
                      32'({rsp_grant, rsp_need_sem}), 32'd0);
            end
        end
    end

    task automatic send(input int idx, input int cid, input bit sec, input string tag);
        req_valid  = 1'b1;
        req_idx    = IW'(idx);
        req_cid    = 3'(cid);
        req_secure = sec;
        exp_q.push_back(model(idx, cid, sec));
        tag_q.push_back(tag);
        sent++;
        @(negedge clk);
    endtask

    task automatic idle();
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_we = 1'b1; reg_addr = 12'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        if (addr >= 'h100 && addr < 'h100 + 8 * NT && addr % 8 == 0)
            cfg_sh[(addr - 'h100) / 8] = data & 32'h00FF_0073;
        if (addr == 'h10) sec_sh[0] = data;
        if (addr == 'h14) sec_sh[1] = data & 32'h00FF_FFFF;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        reg_re = 1'b1; reg_addr = 12'(addr);
        @(negedge clk);
        reg_re = 1'b0;
        check(reg_rdata === exp, tag, "register read", reg_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 32'(got), 32'(sent));
        finish_run();
    end

    initial begin
        for (int i = 0; i < NT; i++) cfg_sh[i] = '0;
        sec_sh[0] = '0; sec_sh[1] = '0;
        repeat (3) @(negedge clk);
        // R1 outputs in reset
        check({rsp_valid, rsp_grant, rsp_need_sem} == 3'b000, "R1", "reset outputs",
              32'({rsp_valid, rsp_grant, rsp_need_sem}), 32'd0);
        check(reg_rdata == 32'd0, "R1", "reset rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 everything open after reset, back-to-back requests (R2)
        send(0, 5, 0, "R1");
        send(55, 7, 0, "R1");
        send(20, 0, 1, "R1");
        idle();
        rd('h100, 32'd0, "R1");
        rd('h10, 32'd0, "R1");

        // R3 entry counts, write ignored, out of range
        rd('hFEC, 32'h040C_0028, "R3");
        wr('hFEC, 32'hFFFF_FFFF);
        rd('hFEC, 32'h040C_0028, "R3");
        send(56, 1, 1, "R3");
        send(255, 0, 1, "R3");
        send(55, 1, 1, "R3");
        idle();

        // R4 field layout
        wr('h100 + 8 * 3, 32'hFFFF_FFFF);
        rd('h100 + 8 * 3, 32'h00FF_0073, "R4");
        send(3, 4, 0, "R7");
        idle();

        // R5 wildcard owner and filter off
        wr('h100 + 8 * 5, 32'h0000_0001);
        send(5, 6, 0, "R5");
        idle();
        wr('h100 + 8 * 5, 32'h0000_0030);
        send(5, 1, 0, "R5");
        idle();

        // R6 static owner 2
        wr('h100 + 8 * 7, 32'h0000_0021);
        send(7, 2, 0, "R6");
        send(7, 3, 0, "R6");
        send(7, 0, 1, "R6");
        idle();

        // R7 allow list {1,6}, owner 4 ignored
        wr('h100 + 8 * 9, 32'h0042_0043);
        send(9, 1, 0, "R7");
        send(9, 4, 0, "R7");
        send(9, 6, 1, "R7");
        idle();

        // R9 semaphore mode without filtering has no effect
        wr('h100 + 8 * 10, 32'h0000_0052);
        send(10, 3, 0, "R9");
        idle();

        // R8 secure-only bits
        wr('h10, 32'h0000_0088);
        send(7, 2, 0, "R8");
        send(7, 2, 1, "R8");
        send(3, 5, 0, "R9");
        send(3, 5, 1, "R8");
        idle();
        wr('h14, 32'hFFFF_FFFF);
        rd('h14, 32'h00FF_FFFF, "R8");
        send(33, 0, 0, "R8");
        send(33, 0, 1, "R8");
        send(55, 6, 0, "R8");
        idle();

        // R10 unmapped, misaligned and hold
        rd('h104, 32'd0, "R10");
        rd('h300, 32'd0, "R10");
        rd('h100 + 8 * 9, 32'h0042_0043, "R10");
        reg_addr = 12'h014;
        repeat (2) @(negedge clk);
        check(reg_rdata == 32'h0042_0043, "R10", "rdata hold", reg_rdata, 32'h0042_0043);

        idle();
        check(exp_q.size() == 0 && got == sent, "R2", "response count",
              32'(got), 32'(sent));
        finish_run();
    end
endmodule